// File: doc/BRIEF.md
# Shared Interrupt Target Router

This block owns the interrupt-targets register window of an interrupt distributor serving up to eight CPUs. Each 32-bit word of the window covers four interrupts, one byte per interrupt. Bit c of a byte names CPU c. The first eight words cover the per-CPU (banked) interrupts 0 to 31. The remaining words cover the shared interrupts. The distributor's interface logic delivers one access per cycle as a word index, a read/write flag, write data and the identity of the requesting CPU.

A write to a shared word reduces each byte to a single CPU: the lowest-numbered set bit wins, and an empty byte falls back to CPU0. The block stores the result as a compact CPU index. The stored indices drive a per-CPU one-hot target bitmap that the pending logic consumes. A read rebuilds the byte view from those indices. The banked words are read-only, and a read of them returns the requester's own bit in every byte. Every write to the shared range raises a one-cycle state-update pulse, so that the pending state can be recomputed.

Top module: `tgt_router`

## Requirements
- R1: After synchronous reset every shared interrupt targets CPU0, so a read of any shared word returns 0x01010101, CPU0's bitmap is all ones and every other CPU's is all zeros, and rd_valid and state_update are low.
- R2: A write to a shared word stores, for each byte, the index of its least significant set bit, so exactly one CPU is selected (0xFF gives CPU0, 0x06 gives CPU1, 0xC0 gives CPU6, 0x80 gives CPU7).
- R3: A written byte of 0x00 selects CPU0.
- R4: A read is answered one cycle after it is accepted, with rd_valid high for that one cycle. For a shared word, each byte holds only the stored target's bit, so it has exactly one bit set. Writes never raise rd_valid.
- R5: Writes to words 0 to 7 (the banked range) change no stored target and raise no state-update pulse.
- R6: A read of any word 0 to 7 returns the one-hot bit of req_cpu repeated in all four bytes, for example 0x04040404 for CPU2.
- R7: state_update is high for exactly the one cycle after each accepted write to a shared word, and is low after reads and banked writes.
- R8: Bit c*NUM_SHARED+i of cpu_target_map is set exactly when shared interrupt i targets CPU c. Each interrupt has exactly one owner. The map changes in the same cycle as the state-update pulse of the write that changed it.
- R9: Byte k (bits 8k+7 to 8k) of word w (w at least 8) belongs to shared interrupt (w-8)*4+k. For example, writing 0x80402010 to word 8 sends shared interrupts 0, 1, 2 and 3 to CPUs 4, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | WORD_W (5) | Word index inside the targets window |
| acc_wdata | input | 32 | Write data, one byte per interrupt |
| req_cpu | input | CPU_W (3) | Index of the CPU making the access |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response word |
| state_update | output | 1 | One-cycle pulse after a shared-range write |
| cpu_target_map | output | NUM_CPUS*NUM_SHARED (768) | Per-CPU one-hot target bitmaps, CPU-major |

## Verification
A shared-word write retires in the same cycle that the next access is accepted, so the state-update pulse, the target-map change and a new read can all fall in one cycle. The bench issues every write immediately followed by a read of the same word, with no idle cycle between them. It then checks three things: that the pulse was high after the write, that the map already showed the new owners, and that the read returned the freshly reduced bytes rather than the old ones. A full sweep of all 256 byte values across the shared words runs this collision on every iteration.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

    localparam int BYTE_W        = 8;
    localparam int REG_W         = 32;
    localparam int SLOTS_PER_REG = REG_W / BYTE_W;
    localparam int PRIV_IRQS     = 32;
    localparam int PRIV_REGS     = PRIV_IRQS / SLOTS_PER_REG;
    localparam int MAX_CPUS      = 8;
    localparam int IDX_W         = 3;

    typedef logic [IDX_W-1:0]  cpu_idx_t;
    typedef logic [BYTE_W-1:0] tgt_byte_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_PRIV_RD,
        ACC_PRIV_WR,
        ACC_SHR_RD,
        ACC_SHR_WR
    } acc_kind_t;

    typedef struct packed {
        logic             valid;
        logic [REG_W-1:0] data;
    } rd_rsp_t;

    // Lowest set bit wins; an empty byte maps to CPU0.
    function automatic cpu_idx_t lowest_cpu(tgt_byte_t b);
        cpu_idx_t r;
        r = '0;
        for (int c = BYTE_W - 1; c >= 0; c--) begin
            if (b[c]) r = cpu_idx_t'(c);
        end
        return r;
    endfunction

    function automatic tgt_byte_t idx_to_byte(cpu_idx_t i);
        return tgt_byte_t'(1) << i;
    endfunction

endpackage

// File: rtl/tgt_access_decode.sv
module tgt_access_decode
    import tgt_pkg::*;
#(
    parameter int NUM_SHARED = 96,
    parameter int WORD_W     = 5,
    parameter int SREG_W     = 5
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [WORD_W-1:0] acc_word,
    output acc_kind_t         kind,
    output logic [SREG_W-1:0] sreg
);
    localparam int SHR_REGS  = NUM_SHARED / SLOTS_PER_REG;
    localparam int TOTAL_REG = PRIV_REGS + SHR_REGS;

    always_comb begin
        kind = ACC_NONE;
        sreg = '0;
        if (acc_valid) begin
            if (int'(acc_word) < PRIV_REGS) begin
                kind = acc_write ? ACC_PRIV_WR : ACC_PRIV_RD;
            end else if (int'(acc_word) < TOTAL_REG) begin
                kind = acc_write ? ACC_SHR_WR : ACC_SHR_RD;
                sreg = SREG_W'(acc_word - WORD_W'(PRIV_REGS));
            end
        end
    end
endmodule

// File: rtl/tgt_byte_reduce.sv
module tgt_byte_reduce
    import tgt_pkg::*;
(
    input  logic [REG_W-1:0]               wdata,
    output logic [SLOTS_PER_REG*IDX_W-1:0] picks
);
    for (genvar k = 0; k < SLOTS_PER_REG; k++) begin : g_slot
        assign picks[k*IDX_W +: IDX_W] = lowest_cpu(wdata[k*BYTE_W +: BYTE_W]);
    end
endmodule

// File: rtl/tgt_index_store.sv
module tgt_index_store
    import tgt_pkg::*;
#(
    parameter int NUM_SHARED = 96,
    parameter int SREG_W     = 5
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [SREG_W-1:0]              wr_reg,
    input  logic [SLOTS_PER_REG*IDX_W-1:0] wr_picks,
    output logic [NUM_SHARED*IDX_W-1:0]    idx_flat
);
    for (genvar i = 0; i < NUM_SHARED; i++) begin : g_irq
        localparam int REG_OF  = i / SLOTS_PER_REG;
        localparam int SLOT_OF = i % SLOTS_PER_REG;
        cpu_idx_t idx_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                idx_q <= '0;
            end else if (wr_en && (int'(wr_reg) == REG_OF)) begin
                idx_q <= wr_picks[SLOT_OF*IDX_W +: IDX_W];
            end
        end

        assign idx_flat[i*IDX_W +: IDX_W] = idx_q;
    end

    // R1: the cycle after reset every target is CPU0
    a_r1_reset_cpu0: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (idx_flat == '0));

    // R5: without a shared write no stored target moves
    a_r5_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(idx_flat));
endmodule

// File: rtl/tgt_cpu_map.sv
module tgt_cpu_map
    import tgt_pkg::*;
#(
    parameter int NUM_CPUS   = 8,
    parameter int NUM_SHARED = 96
) (
    input  logic [NUM_SHARED*IDX_W-1:0]    idx_flat,
    output logic [NUM_CPUS*NUM_SHARED-1:0] cpu_map
);
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        for (genvar i = 0; i < NUM_SHARED; i++) begin : g_irq
            assign cpu_map[c*NUM_SHARED + i] =
                (idx_flat[i*IDX_W +: IDX_W] == cpu_idx_t'(c));
        end
    end
endmodule

// File: rtl/tgt_read_format.sv
module tgt_read_format
    import tgt_pkg::*;
#(
    parameter int NUM_SHARED = 96,
    parameter int SREG_W     = 5,
    parameter int CPU_W      = 3
) (
    input  acc_kind_t                   kind,
    input  logic [SREG_W-1:0]           sreg,
    input  logic [CPU_W-1:0]            req_cpu,
    input  logic [NUM_SHARED*IDX_W-1:0] idx_flat,
    output logic [REG_W-1:0]            word
);
    always_comb begin
        word = '0;
        case (kind)
            ACC_PRIV_RD: begin
                for (int k = 0; k < SLOTS_PER_REG; k++) begin
                    word[k*BYTE_W +: BYTE_W] = idx_to_byte(cpu_idx_t'(req_cpu));
                end
            end
            ACC_SHR_RD: begin
                for (int k = 0; k < SLOTS_PER_REG; k++) begin
                    word[k*BYTE_W +: BYTE_W] = idx_to_byte(
                        idx_flat[(int'(sreg)*SLOTS_PER_REG + k)*IDX_W +: IDX_W]);
                end
            end
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/tgt_router.sv
module tgt_router
    import tgt_pkg::*;
#(
    parameter int NUM_CPUS   = 8,
    parameter int NUM_SHARED = 96,
    localparam int SHR_REGS  = NUM_SHARED / SLOTS_PER_REG,
    localparam int NUM_REGS  = PRIV_REGS + SHR_REGS,
    localparam int WORD_W    = $clog2(NUM_REGS),
    localparam int SREG_W    = (SHR_REGS > 1) ? $clog2(SHR_REGS) : 1,
    localparam int CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int MAP_W     = NUM_CPUS * NUM_SHARED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [WORD_W-1:0] acc_word,
    input  logic [REG_W-1:0]  acc_wdata,
    input  logic [CPU_W-1:0]  req_cpu,
    output logic              rd_valid,
    output logic [REG_W-1:0]  rd_data,
    output logic              state_update,
    output logic [MAP_W-1:0]  cpu_target_map
);
    acc_kind_t                      kind;
    logic [SREG_W-1:0]              sreg;
    logic [SLOTS_PER_REG*IDX_W-1:0] picks;
    logic [NUM_SHARED*IDX_W-1:0]    idx_flat;
    logic [REG_W-1:0]               fmt_word;
    rd_rsp_t                        rsp_q;
    logic                           upd_q;

    tgt_access_decode #(.NUM_SHARED(NUM_SHARED), .WORD_W(WORD_W), .SREG_W(SREG_W)) u_decode (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_word  (acc_word),
        .kind      (kind),
        .sreg      (sreg)
    );

    tgt_byte_reduce u_reduce (
        .wdata (acc_wdata),
        .picks (picks)
    );

    tgt_index_store #(.NUM_SHARED(NUM_SHARED), .SREG_W(SREG_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (kind == ACC_SHR_WR),
        .wr_reg   (sreg),
        .wr_picks (picks),
        .idx_flat (idx_flat)
    );

    tgt_cpu_map #(.NUM_CPUS(NUM_CPUS), .NUM_SHARED(NUM_SHARED)) u_map (
        .idx_flat (idx_flat),
        .cpu_map  (cpu_target_map)
    );

    tgt_read_format #(.NUM_SHARED(NUM_SHARED), .SREG_W(SREG_W), .CPU_W(CPU_W)) u_fmt (
        .kind     (kind),
        .sreg     (sreg),
        .req_cpu  (req_cpu),
        .idx_flat (idx_flat),
        .word     (fmt_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
            upd_q <= 1'b0;
        end else begin
            rsp_q.valid <= (kind == ACC_PRIV_RD) || (kind == ACC_SHR_RD);
            rsp_q.data  <= fmt_word;
            upd_q       <= (kind == ACC_SHR_WR);
        end
    end

    assign rd_valid     = rsp_q.valid;
    assign rd_data      = rsp_q.data;
    assign state_update = upd_q;

    // R7: pulse only after a shared write, and every shared write gives one
    a_r7_pulse_source: assert property (@(posedge clk) disable iff (rst)
        state_update |-> $past(acc_valid && acc_write && (int'(acc_word) >= PRIV_REGS)));
    a_r7_pulse_follows_write: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && (int'(acc_word) >= PRIV_REGS)
         && (int'(acc_word) < NUM_REGS)) |=> state_update);

    // R4: responses only to reads, one bit per byte
    a_r4_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(acc_valid && !acc_write));
    a_r4_bytes_onehot: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($countones(rd_data[7:0]) == 1 && $countones(rd_data[15:8]) == 1 &&
                      $countones(rd_data[23:16]) == 1 && $countones(rd_data[31:24]) == 1));

    // R6: banked read echoes the requester
    a_r6_banked_echo: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(int'(acc_word) < PRIV_REGS)) |->
        (rd_data == {SLOTS_PER_REG{idx_to_byte(cpu_idx_t'($past(req_cpu)))}}));

    // R8: no interrupt has two owners
    for (genvar i = 0; i < NUM_SHARED; i++) begin : g_own
        logic [NUM_CPUS-1:0] col;
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_col
            assign col[c] = cpu_target_map[c*NUM_SHARED + i];
        end
        a_r8_single_owner: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col));
    end
endmodule

// File: tb/tgt_router_tb.sv
module tgt_router_tb;
    localparam int NC   = 8;
    localparam int NS   = 96;
    localparam int PRIV = 8;
    localparam int NW   = PRIV + NS / 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          acc_valid, acc_write;
    logic [4:0]    acc_word;
    logic [31:0]   acc_wdata;
    logic [2:0]    req_cpu;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic          state_update;
    logic [NC*NS-1:0] cpu_target_map;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_idx[NS];
    bit done = 1'b0;

    always #5 clk = ~clk;

    tgt_router #(.NUM_CPUS(NC), .NUM_SHARED(NS)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .acc_valid      (acc_valid),
        .acc_write      (acc_write),
        .acc_word       (acc_word),
        .acc_wdata      (acc_wdata),
        .req_cpu        (req_cpu),
        .rd_valid       (rd_valid),
        .rd_data        (rd_data),
        .state_update   (state_update),
        .cpu_target_map (cpu_target_map)
    );

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int lsb_of(logic [7:0] b);
        for (int k = 0; k < 8; k++) if (b[k]) return k;
        return 0;
    endfunction

    function automatic logic [31:0] exp_word(int w, int cpu);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) begin
            if (w < PRIV) r[k*8 +: 8] = 8'(1) << cpu;
            else          r[k*8 +: 8] = 8'(1) << exp_idx[(w - PRIV) * 4 + k];
        end
        return r;
    endfunction

    function automatic logic [NC*NS-1:0] exp_map();
        logic [NC*NS-1:0] m;
        m = '0;
        for (int i = 0; i < NS; i++) m[exp_idx[i] * NS + i] = 1'b1;
        return m;
    endfunction

    task automatic check_map(string req);
        logic [NC*NS-1:0] e;
        e = exp_map();
        n_chk++;
        if (cpu_target_map !== e) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, cpu_target_map, e);
        end
    endtask

    // Called just after a falling edge; returns at the next falling edge.
    task automatic acc(bit wr, int w, logic [31:0] d, int cpu);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_word  = 5'(w);
        acc_wdata = d;
        req_cpu   = 3'(cpu);
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    task automatic wr_shared(int w, logic [31:0] d);
        acc(1'b1, w, d, 0);
        for (int k = 0; k < 4; k++) exp_idx[(w - PRIV) * 4 + k] = lsb_of(d[k*8 +: 8]);
        check(state_update === 1'b1, "R7 pulse after shared write", 32'(state_update), 32'd1);
        check_map("R8 map after write");
    endtask

    task automatic rd_check(int w, int cpu, string req);
        logic [31:0] e;
        e = exp_word(w, cpu);
        acc(1'b0, w, 32'h0, cpu);
        check(rd_valid === 1'b1 && rd_data === e, req, rd_data, e);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) exp_idx[i] = 0;
        rst = 1'b1; acc_valid = 1'b0; acc_write = 1'b0;
        acc_word = '0; acc_wdata = '0; req_cpu = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(rd_valid === 1'b0, "R1 rd_valid after reset", 32'(rd_valid), 32'd0);
        check(state_update === 1'b0, "R1 state_update after reset", 32'(state_update), 32'd0);
        check_map("R1 map after reset");
        for (int w = PRIV; w < NW; w++) rd_check(w, 0, "R1 shared word reads 0x01010101");

        // R6 banked reads for every requester
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < PRIV; w++) rd_check(w, c, "R6 banked read echo");

        // R5 banked writes ignored
        for (int w = 0; w < PRIV; w++) begin
            acc(1'b1, w, 32'hFFFF_FFFF ^ 32'(w * 33), w);
            check(state_update === 1'b0, "R5 no pulse on banked write", 32'(state_update), 32'd0);
            check(rd_valid === 1'b0, "R4 no response to write", 32'(rd_valid), 32'd0);
        end
        check_map("R5 map unchanged by banked writes");
        for (int w = PRIV; w < NW; w++) rd_check(w, 0, "R5 shared targets unchanged");

        // R9 byte order, R2 single bits
        wr_shared(8, 32'h8040_2010);
        check(cpu_target_map[4*NS+0] && cpu_target_map[5*NS+1] &&
              cpu_target_map[6*NS+2] && cpu_target_map[7*NS+3],
              "R9 byte k of word 8 to interrupt k", 32'(cpu_target_map[7*NS+3]), 32'd1);
        rd_check(8, 0, "R9 readback 0x80402010");

        // R2 multi-bit bytes, R3 zero byte
        wr_shared(9, 32'hC006_00FF);
        rd_check(9, 0, "R2 lowest set bit, R3 zero byte");
        check(rd_data === 32'h4002_0101, "R2 R3 explicit word", rd_data, 32'h4002_0101);
        wr_shared(31, 32'h0000_0000);
        rd_check(31, 0, "R3 all-zero word to CPU0");

        // Sweep of all byte values, each write followed at once by a read
        for (int v = 0; v < 256; v++) begin
            int w;
            logic [31:0] d;
            w = PRIV + (v % (NW - PRIV));
            d = {8'((v * 13) % 256), 8'(255 - v), 8'((v * 7 + 3) % 256), 8'(v)};
            wr_shared(w, d);
            rd_check(w, v % NC, "R2 R4 read right after write sees new targets");
            check(state_update === 1'b0, "R7 no pulse after read", 32'(state_update), 32'd0);
        end

        // Final full readback and map
        for (int w = PRIV; w < NW; w++) rd_check(w, 0, "R4 final shared readback");
        check_map("R8 final map");

        done = 1'b1;
        finish_run();
    end
endmodule